// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block takes one memory request issued by a group of sixteen lanes and turns it into as few aligned bus transactions as its policy allows. Each lane brings an active flag and a byte address, and one element-size code applies to every lane. The result is a stream of transactions, each carrying a naturally aligned base address, a size of 32, 64 or 128 bytes, and a mask of the lanes it serves. The memory behind the bus and the returning data are handled elsewhere.

Two policies are selectable per request. The strict policy merges the request into one wide access only when the active lanes form an aligned, in-order run of elements. If they do not, each active lane gets its own 32-byte transaction. The relaxed policy accepts any lane order. It repeatedly takes the lowest pending address, gathers every pending lane in that address's 128-byte segment, and shrinks the segment to 64 and then 32 bytes while all gathered addresses stay inside one half of it.

A request is accepted on a valid/ready handshake. Its transactions leave on a second valid/ready handshake, and the next request is taken only after the last of them has gone.

Top module: `hwc_coalescer`

## Requirements
- R1: `reqReady` is high only while no transaction of the previous request is outstanding; it is high after reset, and while `txnValid` is high `reqReady` stays low.
- R2: A transaction offered on `txnValid` keeps its address, size and mask until `txnReady` takes it, and the base addresses of one request's transactions never decrease.
- R3: `txnSize` encodes 0 = 32 bytes, 1 = 64 bytes, 2 = 128 bytes, and every `txnAddr` is a multiple of its own size.
- R4: Element sizes are coded by `reqElem` as 0 = 4 bytes, 1 = 8 bytes, 2 or 3 = 16 bytes. In strict mode (`reqRelaxed` = 0), a request is coalesced when every active lane k addresses B + k·E, where E is the element size and B is a multiple of 16·E. It is then served by a 64-byte transaction for 4-byte elements, by a 128-byte transaction for 8-byte elements, and for 16-byte elements by one 128-byte transaction for each half (lanes 0–7 at B, lanes 8–15 at B+128) that holds an active lane.
- R5: In strict mode, the addresses of inactive lanes are ignored, and a sparse active set still coalesces.
- R6: If the strict rule is broken, each active lane gets its own 32-byte transaction at its address rounded down to 32, with a one-hot mask. These are issued in ascending address order, with equal addresses taken in ascending lane order.
- R7: In relaxed mode, any lane order is accepted. Each active lane is served by exactly one transaction, and each transaction serves at least one lane.
- R8: In relaxed mode, each transaction starts as the 128-byte segment holding the lowest pending address. It becomes 64 bytes when all its lanes lie in one 64-byte half, and 32 bytes when they also lie in one 32-byte quarter.
- R9: In relaxed mode, a contiguous run that crosses a 128-byte boundary is served by two transactions.
- R10: A request with no active lanes produces no transaction and leaves the block ready for the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be accepted |
| reqRelaxed | input | 1 | 1 = relaxed policy, 0 = strict policy |
| reqElem | input | 2 | Element size code |
| reqActive | input | LANES | Active flag per lane |
| reqAddr | input | LANES*AW | Byte address per lane, lane k at bits k*AW upward |
| txnValid | output | 1 | Transaction offered |
| txnReady | input | 1 | Transaction taken |
| txnAddr | output | AW | Transaction base address |
| txnSize | output | 2 | Transaction size code |
| txnMask | output | LANES | Lanes served by this transaction |

## Verification
Aligned, in-order runs of 4-, 8- and 16-byte elements show that strict merging picks the right width and splits the 256-byte case into halves. Sparse masks with junk addresses in the idle lanes show that inactive lanes are ignored. A swapped lane pair and a misaligned run are sent in strict mode, and the same misaligned run is also sent in relaxed mode. These cases separate the per-element fallback (with its ordering of equal addresses) from relaxed segment merging. Permuted and scattered relaxed requests exercise the 128/64/32 shrinking, a run crossing a 128-byte line gives the two-transaction split, and a stalled consumer together with an empty request checks the handshakes.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef struct packed {
    logic load;
    logic advance;
  } ctrl_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/hwc_ctrl.sv
module hwc_ctrl
  import hwc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         txnReady,
  input  logic         pendEmpty,
  input  logic         lastTxn,
  output logic         reqReady,
  output logic         txnValid,
  output ctrl_strobe_t strobe
);
  ctrl_state_e state, stateNext;

  assign reqReady       = (state == ST_IDLE);
  assign txnValid       = (state == ST_BUSY) && !pendEmpty;
  assign strobe.load    = reqReady && reqValid;
  assign strobe.advance = txnValid && txnReady;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (reqValid) stateNext = ST_BUSY;
      ST_BUSY: if (pendEmpty || (strobe.advance && lastTxn)) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end
endmodule

// File: rtl/hwc_datapath.sv
module hwc_datapath
  import hwc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LANES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrl_strobe_t         strobe,
  input  logic                 reqRelaxed,
  input  logic [1:0]           reqElem,
  input  logic [LANES-1:0]     reqActive,
  input  logic [LANES*AW-1:0]  reqAddr,
  output logic                 pendEmpty,
  output logic                 lastTxn,
  output logic [AW-1:0]        txnAddr,
  output logic [1:0]           txnSize,
  output logic [LANES-1:0]     txnMask
);
  localparam int LANE_LOG = $clog2(LANES);
  localparam int IW       = (LANE_LOG > 0) ? LANE_LOG : 1;

  function automatic int elemLogOf(input logic [1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 3;
      default: return 4;
    endcase
  endfunction

  // Strict-rule evaluation on the incoming request
  logic [AW-1:0] regionMask, refAddr;
  logic          refFound, inStrictOk;
  int            inElemLog;

  always_comb begin
    inElemLog  = elemLogOf(reqElem);
    regionMask = (AW'(1) << (inElemLog + LANE_LOG)) - AW'(1);
    refAddr    = '0;
    refFound   = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (reqActive[k] && !refFound) begin
        refAddr  = reqAddr[k*AW +: AW];
        refFound = 1'b1;
      end
    end
    inStrictOk = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      if (reqActive[k]) begin
        if ((reqAddr[k*AW +: AW] & ~regionMask) != (refAddr & ~regionMask)) inStrictOk = 1'b0;
        if ((reqAddr[k*AW +: AW] & regionMask) != (AW'(k) << inElemLog))     inStrictOk = 1'b0;
      end
    end
  end

  // Latched request
  logic [AW-1:0]    addrR [LANES];
  logic [LANES-1:0] pendR;
  logic             relaxedR, strictOkR;
  logic [1:0]       elemR;
  logic [LANES-1:0] selMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LANES; k++) addrR[k] <= '0;
      pendR     <= '0;
      relaxedR  <= 1'b0;
      strictOkR <= 1'b0;
      elemR     <= 2'd0;
    end else if (strobe.load) begin
      for (int k = 0; k < LANES; k++) addrR[k] <= reqAddr[k*AW +: AW];
      pendR     <= reqActive;
      relaxedR  <= reqRelaxed;
      strictOkR <= inStrictOk;
      elemR     <= reqElem;
    end else if (strobe.advance) begin
      pendR <= pendR & ~selMask;
    end
  end

  // Segment selection for the next transaction
  int               segLog, regionLogR;
  logic             single, minFound, same6, same5;
  logic [IW-1:0]    minIdx;
  logic [AW-1:0]    minAddr;
  logic [LANES-1:0] inSeg;
  logic [1:0]       sizeCode;

  always_comb begin
    regionLogR = elemLogOf(elemR) + LANE_LOG;
    if (relaxedR)       segLog = 7;
    else if (strictOkR) segLog = (regionLogR < 7) ? regionLogR : 7;
    else                segLog = 5;
    single = !relaxedR && !strictOkR;

    minFound = 1'b0;
    minIdx   = '0;
    minAddr  = '0;
    for (int k = 0; k < LANES; k++) begin
      if (pendR[k] && (!minFound || (addrR[k] < minAddr))) begin
        minFound = 1'b1;
        minIdx   = IW'(k);
        minAddr  = addrR[k];
      end
    end

    for (int k = 0; k < LANES; k++)
      inSeg[k] = pendR[k] && ((addrR[k] >> segLog) == (minAddr >> segLog));
    selMask = single ? (LANES'(1) << minIdx) : inSeg;

    same6 = 1'b1;
    same5 = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      if (selMask[k]) begin
        if (addrR[k][6] != minAddr[6]) same6 = 1'b0;
        if (addrR[k][5] != minAddr[5]) same5 = 1'b0;
      end
    end

    if (relaxedR) sizeCode = same6 ? (same5 ? 2'd0 : 2'd1) : 2'd2;
    else          sizeCode = 2'(segLog - 5);
  end

  assign txnAddr   = minAddr & ~((AW'(1) << (5 + int'(sizeCode))) - AW'(1));
  assign txnSize   = sizeCode;
  assign txnMask   = selMask;
  assign pendEmpty = (pendR == '0);
  assign lastTxn   = (selMask == pendR);
endmodule

// File: rtl/hwc_coalescer.sv
module hwc_coalescer
  import hwc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LANES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqRelaxed,
  input  logic [1:0]          reqElem,
  input  logic [LANES-1:0]    reqActive,
  input  logic [LANES*AW-1:0] reqAddr,
  output logic                txnValid,
  input  logic                txnReady,
  output logic [AW-1:0]       txnAddr,
  output logic [1:0]          txnSize,
  output logic [LANES-1:0]    txnMask
);
  ctrl_strobe_t strobe;
  logic         pendEmpty, lastTxn;

  hwc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .txnReady(txnReady),
    .pendEmpty(pendEmpty), .lastTxn(lastTxn),
    .reqReady(reqReady), .txnValid(txnValid), .strobe(strobe)
  );

  hwc_datapath #(.AW(AW), .LANES(LANES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .reqRelaxed(reqRelaxed), .reqElem(reqElem), .reqActive(reqActive), .reqAddr(reqAddr),
    .pendEmpty(pendEmpty), .lastTxn(lastTxn),
    .txnAddr(txnAddr), .txnSize(txnSize), .txnMask(txnMask)
  );
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
  parameter int AW    = 32,
  parameter int LANES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             reqReady,
  input logic             txnValid,
  input logic             txnReady,
  input logic [AW-1:0]    txnAddr,
  input logic [1:0]       txnSize,
  input logic [LANES-1:0] txnMask
);
  logic             haveLast;
  logic [AW-1:0]    lastAddr;
  logic [LANES-1:0] served;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haveLast <= 1'b0;
      lastAddr <= '0;
      served   <= '0;
    end else if (reqValid && reqReady) begin
      haveLast <= 1'b0;
      served   <= '0;
    end else if (txnValid && txnReady) begin
      haveLast <= 1'b1;
      lastAddr <= txnAddr;
      served   <= served | txnMask;
    end
  end

  p_busy_no_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    txnValid |-> !reqReady);

  p_hold_stalled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (txnValid && !txnReady) |=> (txnValid && $stable(txnAddr) && $stable(txnSize) && $stable(txnMask)));

  p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (txnValid && haveLast) |-> (txnAddr >= lastAddr));

  p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txnValid |-> ((txnSize != 2'd3) &&
                  (({1'b0, txnAddr[6:0]} & ((8'd32 << txnSize) - 8'd1)) == 8'd0)));

  p_lane_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txnValid |-> ((txnMask != '0) && ((txnMask & served) == '0)));
endmodule

bind hwc_coalescer hwc_checker #(.AW(AW), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
  .txnValid(txnValid), .txnReady(txnReady), .txnAddr(txnAddr),
  .txnSize(txnSize), .txnMask(txnMask)
);

// File: tb/hwc_coalescer_tb.sv
`timescale 1ns/1ps
module hwc_coalescer_tb;
  localparam int AW = 32;
  localparam int LANES = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic reqRelaxed = 1'b0;
  logic [1:0] reqElem = 2'd0;
  logic [LANES-1:0] reqActive = '0;
  logic [LANES*AW-1:0] reqAddr = '0;
  logic txnReady = 1'b1;
  logic reqReady, txnValid;
  logic [AW-1:0] txnAddr;
  logic [1:0] txnSize;
  logic [LANES-1:0] txnMask;

  always #2.5 clk = ~clk;

  hwc_coalescer #(.AW(AW), .LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqRelaxed(reqRelaxed), .reqElem(reqElem), .reqActive(reqActive), .reqAddr(reqAddr),
    .txnValid(txnValid), .txnReady(txnReady), .txnAddr(txnAddr),
    .txnSize(txnSize), .txnMask(txnMask)
  );

  int nChecks = 0;
  int nFail = 0;
  int overlapErr = 0;
  bit stallMode = 1'b0;

  logic [AW-1:0] laneA [LANES];
  logic [AW-1:0] gotAddr [64];
  logic [1:0] gotSize [64];
  logic [LANES-1:0] gotMask [64];
  int gotN = 0;
  logic [AW-1:0] expAddr [64];
  logic [1:0] expSize [64];
  logic [LANES-1:0] expMask [64];
  int expN = 0;

  // Monitor, away from the rising edge
  always @(negedge clk) begin
    if (txnValid && txnReady && gotN < 64) begin
      gotAddr[gotN] = txnAddr;
      gotSize[gotN] = txnSize;
      gotMask[gotN] = txnMask;
      gotN++;
    end
    if (txnValid && reqReady) overlapErr++;
    if (stallMode) txnReady = ~txnReady;
    else txnReady = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic addExp(input logic [AW-1:0] a, input logic [1:0] s, input logic [LANES-1:0] m);
    expAddr[expN] = a;
    expSize[expN] = s;
    expMask[expN] = m;
    expN++;
  endtask

  task automatic runReq(input string req, input bit relaxed, input logic [1:0] elem,
                        input logic [LANES-1:0] act);
    int w;
    gotN = 0;
    @(negedge clk);
    reqRelaxed = relaxed;
    reqElem = elem;
    reqActive = act;
    for (int k = 0; k < LANES; k++) reqAddr[k*AW +: AW] = laneA[k];
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    w = 0;
    while (!reqReady && w < 500) begin
      @(negedge clk);
      w++;
    end
    check(reqReady, req, "ready after request", 64'(reqReady), 64'd1);
    check(gotN == expN, req, "transaction count", 64'(gotN), 64'(expN));
    for (int i = 0; i < expN && i < gotN; i++) begin
      check(gotAddr[i] == expAddr[i], req, $sformatf("txn %0d addr", i), 64'(gotAddr[i]), 64'(expAddr[i]));
      check(gotSize[i] == expSize[i], req, $sformatf("txn %0d size", i), 64'(gotSize[i]), 64'(expSize[i]));
      check(gotMask[i] == expMask[i], req, $sformatf("txn %0d mask", i), 64'(gotMask[i]), 64'(expMask[i]));
    end
    expN = 0;
  endtask

  task automatic fillLinear(input logic [AW-1:0] base, input int step);
    for (int k = 0; k < LANES; k++) laneA[k] = base + AW'(k * step);
  endtask

  // R4: aligned in-order runs, three element sizes
  task automatic t_strictAligned;
    fillLinear(32'h1000, 4);
    addExp(32'h1000, 2'd1, 16'hFFFF);
    runReq("R4 strict 4B", 1'b0, 2'd0, 16'hFFFF);
    fillLinear(32'h2000, 8);
    addExp(32'h2000, 2'd2, 16'hFFFF);
    runReq("R4 strict 8B", 1'b0, 2'd1, 16'hFFFF);
    fillLinear(32'h3000, 16);
    addExp(32'h3000, 2'd2, 16'h00FF);
    addExp(32'h3080, 2'd2, 16'hFF00);
    runReq("R4 strict 16B", 1'b0, 2'd2, 16'hFFFF);
  endtask

  // R5: sparse masks, junk in inactive lanes
  task automatic t_strictSparse;
    fillLinear(32'h1040, 4);
    for (int k = 0; k < LANES; k++) if (k[2]) laneA[k] = 32'hDEAD0000 + AW'(k);
    addExp(32'h1040, 2'd1, 16'h0F0F);
    runReq("R5 strict sparse", 1'b0, 2'd0, 16'h0F0F);
    fillLinear(32'h4000, 16);
    for (int k = 0; k < 8; k++) laneA[k] = 32'h0BAD0003;
    addExp(32'h4080, 2'd2, 16'hFF00);
    runReq("R5 strict upper half", 1'b0, 2'd2, 16'hFF00);
  endtask

  // R6: fallback for swapped lanes and misaligned run
  task automatic t_strictFallback;
    fillLinear(32'h1000, 4);
    laneA[0] = 32'h1004;
    laneA[1] = 32'h1000;
    addExp(32'h1000, 2'd0, 16'h0002);
    addExp(32'h1000, 2'd0, 16'h0001);
    addExp(32'h1000, 2'd0, 16'h0004);
    addExp(32'h1000, 2'd0, 16'h0008);
    runReq("R6 strict swapped", 1'b0, 2'd0, 16'h000F);
    fillLinear(32'h1020, 4);
    for (int k = 0; k < LANES; k++)
      addExp((k < 8) ? 32'h1020 : 32'h1040, 2'd0, 16'(1 << k));
    runReq("R6 strict misaligned", 1'b0, 2'd0, 16'hFFFF);
  endtask

  // R7 R8 R9: relaxed merging and shrinking
  task automatic t_relaxed;
    fillLinear(32'h1020, 4);
    addExp(32'h1000, 2'd2, 16'hFFFF);
    runReq("R8 relaxed no shrink", 1'b1, 2'd0, 16'hFFFF);
    for (int k = 0; k < LANES; k++) laneA[k] = 32'h2000 + AW'(4 * (15 - k));
    addExp(32'h2000, 2'd1, 16'hFFFF);
    runReq("R7 relaxed permuted", 1'b1, 2'd0, 16'hFFFF);
    fillLinear(32'h1060, 4);
    addExp(32'h1060, 2'd0, 16'h00FF);
    addExp(32'h1080, 2'd0, 16'hFF00);
    runReq("R9 relaxed line cross", 1'b1, 2'd0, 16'hFFFF);
    fillLinear(32'h9000, 8);
    laneA[0] = 32'h5000;
    laneA[1] = 32'h5100;
    laneA[2] = 32'h5008;
    laneA[3] = 32'h50C0;
    addExp(32'h5000, 2'd0, 16'h0005);
    addExp(32'h50C0, 2'd0, 16'h0008);
    addExp(32'h5100, 2'd0, 16'h0002);
    runReq("R8 relaxed scattered", 1'b1, 2'd1, 16'h000F);
  endtask

  // R10: empty request
  task automatic t_empty;
    fillLinear(32'h7000, 4);
    runReq("R10 empty", 1'b1, 2'd0, 16'h0000);
    runReq("R10 empty strict", 1'b0, 2'd0, 16'h0000);
  endtask

  // R1 R2: stalled consumer
  task automatic t_backpressure;
    overlapErr = 0;
    stallMode = 1'b1;
    fillLinear(32'h3000, 16);
    addExp(32'h3000, 2'd2, 16'h00FF);
    addExp(32'h3080, 2'd2, 16'hFF00);
    runReq("R2 stalled 16B", 1'b0, 2'd2, 16'hFFFF);
    fillLinear(32'h1020, 4);
    for (int k = 0; k < LANES; k++)
      addExp((k < 8) ? 32'h1020 : 32'h1040, 2'd0, 16'(1 << k));
    runReq("R2 stalled fallback", 1'b0, 2'd0, 16'hFFFF);
    stallMode = 1'b0;
    check(overlapErr == 0, "R1", "ready while transaction pending", 64'(overlapErr), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int k = 0; k < LANES; k++) laneA[k] = '0;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b0 || reqReady == 1'b1, "R1", "ready known in reset", 64'(reqReady), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "reset ready", 64'(reqReady), 64'd1);
    check(txnValid == 1'b0, "R1", "reset txnValid", 64'(txnValid), 64'd0);
    t_strictAligned();
    t_strictSparse();
    t_strictFallback();
    t_relaxed();
    t_empty();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule